// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the arbitration core of an eight-input programmable interrupt controller. A command decoder outside the block owns the pending, in-service and mask vectors, the lowest-priority pointer and two mode flags, and presents them on the inputs. Each cycle the resolver answers two questions combinationally. The first is which pending line, if any, may interrupt the processor now. The second is which in-service line a non-specific end-of-interrupt command would retire.

Priority is circular. The line just above the programmable lowest-priority pointer ranks highest, and the order wraps so that the pointer's own line is considered last. Moving the pointer after each service gives rotating priority. Two modes change how in-service lines block other requests. With the selective mask mode on, in-service state is disregarded and only the mask decides which lines may interrupt. With the nested-cascade mode on, the in-service bit of the cascade input no longer blocks, so a downstream controller that is already being serviced can raise a new request.

Top module: `rot_prio_resolver`

## Requirements
- R1: Priority runs from line `(low_pin+1) mod 8` upward and wraps around, with line `low_pin` ranked last. With `low_pin` = 7, line 0 ranks highest.
- R2: A line is a grant candidate only when its `req_vec` bit is 1 and its `mask_vec` bit is 0. When no such line exists, `grant_valid` is 0.
- R3: With both modes off, the scan stops with no grant at the first line, in priority order, whose `isr_vec` bit is 1. This applies when that line ranks at or above the best candidate, including when it is the same line. An in-service bit ranked below the best candidate does not block it.
- R4: With `smm_en` = 1, `isr_vec` has no effect on the grant. The highest-ranked unmasked pending line always wins.
- R5: With `sfnm_en` = 1 and `smm_en` = 0, the `isr_vec` bit of line 2 (the cascade input) does not block the grant. The in-service bits of all other lines still block it.
- R6: `eoi_pin` is the highest-ranked line, in the R1 order, whose `isr_vec` bit is 1. `eoi_valid` is 0 when `isr_vec` is all zero.
- R7: With `smm_en` = 1, the end-of-interrupt search skips every in-service line whose `mask_vec` bit is 1. When all in-service lines are masked, `eoi_valid` is 0.
- R8: When a valid flag is 0, its pin output carries no meaning. With all inputs zero, both valid flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_vec | input | 8 | Pending request per line |
| isr_vec | input | 8 | In-service bit per line |
| mask_vec | input | 8 | Mask bit per line; 1 disables the line |
| low_pin | input | 3 | Line that currently ranks lowest |
| smm_en | input | 1 | Selective mask mode |
| sfnm_en | input | 1 | Nested-cascade mode (cascade line not blocked by its in-service bit) |
| grant_valid | output | 1 | A line may interrupt now |
| grant_pin | output | 3 | Winning line |
| eoi_valid | output | 1 | A target for non-specific end-of-interrupt exists |
| eoi_pin | output | 3 | Highest-ranked in-service line eligible for retirement |

## Verification
Paired requests at the two ends of the range, checked under different pointer values, show whether the start of the circular order is placed and wrapped correctly. In-service bits placed below, at and above a request show whether blocking applies to same-or-higher levels and not to lower ones. The same in-service patterns are then repeated with each mode on, which shows what each mode removes from the blocking set and what it leaves in place. A long run of pseudo-random vector and pointer combinations is added to reach mixed cases that the hand-picked patterns do not cover.

// File: rtl/rprio_pkg.sv
package rprio_pkg;
   typedef enum logic {
      ROT_INDEX_MUX = 1'b0,
      ROT_DOUBLE_SHIFT = 1'b1
   } rot_style_e;
endpackage

// File: rtl/rprio_rotate.sv
module rprio_rotate #(
   parameter int unsigned N = 8,
   parameter int unsigned PW = 3,
   parameter rprio_pkg::rot_style_e STYLE = rprio_pkg::ROT_INDEX_MUX
) (
   input  logic [N-1:0]  din,
   input  logic [PW-1:0] off,
   output logic [N-1:0]  dout
);
   // dout[i] = din[(i + off) mod N]; N is a power of two, so PW-bit sums wrap.
   generate
      if (STYLE == rprio_pkg::ROT_DOUBLE_SHIFT) begin : g_shift
         logic [2*N-1:0] dbl;
         assign dbl  = {din, din} >> off;
         assign dout = dbl[N-1:0];
      end else begin : g_mux
         for (genvar i = 0; i < N; i++) begin : g_bit
            logic [PW-1:0] src;
            assign src     = PW'(i) + off;
            assign dout[i] = din[src];
         end
      end
   endgenerate
endmodule

// File: rtl/rprio_first.sv
module rprio_first #(
   parameter int unsigned N = 8,
   parameter int unsigned PW = 3
) (
   input  logic [N-1:0]  vec,
   output logic          hit,
   output logic [PW-1:0] idx
);
   always_comb begin
      hit = |vec;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = PW'(i);
      end
   end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
   parameter int unsigned N = 8,
   parameter int unsigned CASCADE_PIN = 2,
   parameter rprio_pkg::rot_style_e ROT_STYLE = rprio_pkg::ROT_INDEX_MUX,
   localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_vec,
   input  logic [N-1:0]  isr_vec,
   input  logic [N-1:0]  mask_vec,
   input  logic [PW-1:0] low_pin,
   input  logic          smm_en,
   input  logic          sfnm_en,
   output logic          grant_valid,
   output logic [PW-1:0] grant_pin,
   output logic          eoi_valid,
   output logic [PW-1:0] eoi_pin
);
   localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE_PIN;

   generate
      if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
         $error("rot_prio_resolver: N must be a power of two, at least 2");
      end
      if (CASCADE_PIN >= N) begin : g_bad_casc
         $error("rot_prio_resolver: CASCADE_PIN out of range");
      end
   endgenerate

   logic [PW-1:0] off;
   logic [N-1:0]  elig, blk, eoi_src;
   logic [N-1:0]  elig_r, blk_r, eoi_r;
   logic          stop_hit, eoi_hit;
   logic [PW-1:0] stop_idx, eoi_idx;

   assign off  = low_pin + PW'(1);
   assign elig = req_vec & ~mask_vec;

   always_comb begin
      if (smm_en)       blk = '0;
      else if (sfnm_en) blk = isr_vec & ~CASC_BIT;
      else              blk = isr_vec;
   end

   assign eoi_src = smm_en ? (isr_vec & ~mask_vec) : isr_vec;

   rprio_rotate #(.N(N), .PW(PW), .STYLE(ROT_STYLE)) i_rot_elig (
      .din(elig), .off(off), .dout(elig_r));
   rprio_rotate #(.N(N), .PW(PW), .STYLE(ROT_STYLE)) i_rot_blk (
      .din(blk), .off(off), .dout(blk_r));
   rprio_rotate #(.N(N), .PW(PW), .STYLE(ROT_STYLE)) i_rot_eoi (
      .din(eoi_src), .off(off), .dout(eoi_r));

   // First line in rank order that is either a candidate or a blocker.
   rprio_first #(.N(N), .PW(PW)) i_first_grant (
      .vec(elig_r | blk_r), .hit(stop_hit), .idx(stop_idx));
   rprio_first #(.N(N), .PW(PW)) i_first_eoi (
      .vec(eoi_r), .hit(eoi_hit), .idx(eoi_idx));

   assign grant_valid = stop_hit & ~blk_r[stop_idx];
   assign grant_pin   = stop_idx + off;
   assign eoi_valid   = eoi_hit;
   assign eoi_pin     = eoi_idx + off;
endmodule

// File: rtl/rprio_checker.sv
module rprio_checker #(
   parameter int unsigned N = 8,
   parameter int unsigned PW = 3,
   parameter int unsigned CASCADE_PIN = 2
) (
   input logic [N-1:0]  req_vec,
   input logic [N-1:0]  isr_vec,
   input logic [N-1:0]  mask_vec,
   input logic [PW-1:0] low_pin,
   input logic          smm_en,
   input logic          sfnm_en,
   input logic          grant_valid,
   input logic [PW-1:0] grant_pin,
   input logic          eoi_valid,
   input logic [PW-1:0] eoi_pin
);
   localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE_PIN;
   logic known;
   assign known = !$isunknown({req_vec, isr_vec, mask_vec, low_pin, smm_en, sfnm_en,
                               grant_valid, grant_pin, eoi_valid, eoi_pin});

   always_comb begin
      if (known) begin
         assert_grant_unmasked_R2: assert (!grant_valid ||
            (req_vec[grant_pin] && !mask_vec[grant_pin]))
            else $error("grant on a line that is not pending or is masked");
         assert_grant_not_in_service_R3: assert (!grant_valid || smm_en ||
            (sfnm_en && grant_pin == PW'(CASCADE_PIN)) || !isr_vec[grant_pin])
            else $error("grant on a line already in service");
         assert_smm_always_grants_R4: assert (!smm_en ||
            ((req_vec & ~mask_vec) == '0) || grant_valid)
            else $error("selective mask mode blocked an eligible line");
         assert_cascade_not_blocking_R5: assert (!(sfnm_en && !smm_en &&
            isr_vec == CASC_BIT && (req_vec & ~mask_vec) != '0) || grant_valid)
            else $error("cascade in-service bit blocked in nested-cascade mode");
         assert_eoi_in_service_R6: assert (!eoi_valid || isr_vec[eoi_pin])
            else $error("eoi target is not in service");
         assert_eoi_skips_masked_R7: assert (!(eoi_valid && smm_en) || !mask_vec[eoi_pin])
            else $error("eoi target masked in selective mask mode");
         assert_idle_no_valid_R8: assert (((req_vec & ~mask_vec) != '0 || !grant_valid) &&
            (isr_vec != '0 || !eoi_valid))
            else $error("valid flag raised with nothing qualifying");
      end
   end
endmodule

bind rot_prio_resolver rprio_checker #(.N(N), .PW(PW), .CASCADE_PIN(CASCADE_PIN)) i_rprio_checker (
   .req_vec(req_vec), .isr_vec(isr_vec), .mask_vec(mask_vec), .low_pin(low_pin),
   .smm_en(smm_en), .sfnm_en(sfnm_en), .grant_valid(grant_valid),
   .grant_pin(grant_pin), .eoi_valid(eoi_valid), .eoi_pin(eoi_pin));

// File: tb/test_rot_prio_resolver.sv
`timescale 1ns/1ps
module test_rot_prio_resolver;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [7:0] req_vec = '0, isr_vec = '0, mask_vec = '0;
   logic [2:0] low_pin = 3'd7;
   logic       smm_en = 1'b0, sfnm_en = 1'b0;
   logic       grant_valid, eoi_valid;
   logic [2:0] grant_pin, eoi_pin;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   typedef struct {
      logic gv; logic [2:0] gp; logic ev; logic [2:0] ep; string tag;
   } exp_t;
   exp_t sb[$];

   rot_prio_resolver i_rot_prio_resolver (
      .req_vec(req_vec), .isr_vec(isr_vec), .mask_vec(mask_vec), .low_pin(low_pin),
      .smm_en(smm_en), .sfnm_en(sfnm_en), .grant_valid(grant_valid),
      .grant_pin(grant_pin), .eoi_valid(eoi_valid), .eoi_pin(eoi_pin));

   // Reference scan written from the requirements, one line at a time.
   function automatic exp_t model(logic [7:0] rq, logic [7:0] is, logic [7:0] mk,
                                  logic [2:0] lo, logic sm, logic sf, string tag);
      exp_t e;
      e.gv = 0; e.gp = 0; e.ev = 0; e.ep = 0; e.tag = tag;
      for (int k = 0; k < 8; k++) begin
         logic [2:0] p;
         p = lo + 3'(k + 1);
         if (!sm && is[p] && !(sf && p == 3'd2)) break;
         if (rq[p] && !mk[p]) begin e.gv = 1; e.gp = p; break; end
      end
      for (int k = 0; k < 8; k++) begin
         logic [2:0] p;
         p = lo + 3'(k + 1);
         if (is[p] && !(sm && mk[p])) begin e.ev = 1; e.ep = p; break; end
      end
      return e;
   endfunction

   task automatic apply(logic [7:0] rq, logic [7:0] is, logic [7:0] mk,
                        logic [2:0] lo, logic sm, logic sf, string tag);
      @(negedge clk);
      req_vec = rq; isr_vec = is; mask_vec = mk; low_pin = lo; smm_en = sm; sfnm_en = sf;
      sb.push_back(model(rq, is, mk, lo, sm, sf, tag));
   endtask

   // Monitor: compares one expected item per rising edge.
   initial begin
      forever begin
         @(posedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (grant_valid !== e.gv || (e.gv && grant_pin !== e.gp)) begin
               failures++;
               $display("FAIL %s grant: actual valid=%0b pin=%0d expected valid=%0b pin=%0d",
                        e.tag, grant_valid, grant_pin, e.gv, e.gp);
            end
            checks++;
            if (eoi_valid !== e.ev || (e.ev && eoi_pin !== e.ep)) begin
               failures++;
               $display("FAIL %s eoi: actual valid=%0b pin=%0d expected valid=%0b pin=%0d",
                        e.tag, eoi_valid, eoi_pin, e.ev, e.ep);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R8 watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      apply(8'h00, 8'h00, 8'h00, 3'd7, 0, 0, "R8 idle inputs");
      apply(8'h81, 8'h00, 8'h00, 3'd7, 0, 0, "R1 line0 first");
      apply(8'h81, 8'h00, 8'h00, 3'd0, 0, 0, "R1 wrap picks line7");
      apply(8'h11, 8'h00, 8'h00, 3'd3, 0, 0, "R1 start above pointer");
      apply(8'h10, 8'h00, 8'h00, 3'd4, 0, 0, "R1 pointer line alone");
      apply(8'h03, 8'h00, 8'h01, 3'd7, 0, 0, "R2 masked line skipped");
      apply(8'h03, 8'h00, 8'h03, 3'd7, 0, 0, "R2 all masked");
      apply(8'h01, 8'h02, 8'h00, 3'd7, 0, 0, "R3 lower isr no block");
      apply(8'h02, 8'h01, 8'h00, 3'd7, 0, 0, "R3 higher isr blocks");
      apply(8'h04, 8'h04, 8'h00, 3'd7, 0, 0, "R3 same level blocks");
      apply(8'h02, 8'h01, 8'h00, 3'd7, 1, 0, "R4 smm ignores isr");
      apply(8'h04, 8'h04, 8'h00, 3'd7, 1, 0, "R4 smm same level");
      apply(8'h08, 8'h04, 8'h00, 3'd7, 0, 1, "R5 cascade isr ignored");
      apply(8'h08, 8'h04, 8'h00, 3'd7, 0, 0, "R5 cascade isr blocks without mode");
      apply(8'h08, 8'h02, 8'h00, 3'd7, 0, 1, "R5 other isr still blocks");
      apply(8'h00, 8'h28, 8'h00, 3'd7, 0, 0, "R6 eoi highest isr");
      apply(8'h00, 8'h28, 8'h00, 3'd3, 0, 0, "R6 eoi rotated");
      apply(8'h00, 8'h28, 8'h08, 3'd7, 1, 0, "R7 smm skips masked isr");
      apply(8'h00, 8'h28, 8'h08, 3'd7, 0, 0, "R7 mask ignored without smm");
      apply(8'h00, 8'h28, 8'h28, 3'd7, 1, 0, "R7 all isr masked");
      for (int n = 0; n < 300; n++) begin
         apply(8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom),
               1'($urandom), 1'($urandom), "R1 mixed pattern");
      end
      @(posedge clk);
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule